// File: doc/BRIEF.md
# Priority Multi-Master Bus Router

This block sits between three bus masters and six memory-mapped slaves. The bus is a simple request/grant bus. Each master and each slave has two independent channels, one for reads and one for writes. Each channel carries a request, a grant, a 4-bit byte enable, a 32-bit address and 32-bit data.

For every master, the router decodes the address of each channel against a base/mask pair per slave. For every slave, it picks one requesting master by fixed priority and forwards that request. It then returns the slave's grant to the winning master. A read grant causes the slave's data to be steered back to that master one cycle later.

A master whose grant stays low keeps its request up and retries. An access that hits no slave is granted at once and has no effect: a read of that kind returns zero and a write of that kind is dropped.

Top module: `bus_prio_router`

## Requirements
- R1: A read request is forwarded to slave s when (address AND NOT mask[s]) equals base[s], with address and byte enable unchanged. The default map is: slave 0 at 0x0000_0000, slave 1 at 0x0000_8000, slave 2 at 0x0001_0000 and slave 3 at 0x0002_0000, each with mask 0x0000_0FFF; slave 4 at 0x0003_0000 with mask 0x0000_0003; slave 5 at 0x0003_1000 with mask 0x0000_000F.
- R2: When several masters address the same slave in one cycle, only the lowest-numbered of them is forwarded and can be granted. The others see their grant low in that cycle.
- R3: Masters that address different slaves are all forwarded and granted in the same cycle.
- R4: For a request that hits a slave, the master's grant equals that slave's grant in the same cycle. A slave that holds its grant low leaves the master ungranted.
- R5: A read that hits no slave is granted in the same cycle and raises no slave request. The master sees zero read data in the following cycle.
- R6: A write that hits no slave is granted in the same cycle and raises no slave write request.
- R7: One cycle after a granted read that hits slave s, the master's read data equals slave s's read data. A master that had no read grant in the previous cycle sees zero.
- R8: Read and write channels are arbitrated separately. One master can hold a read grant at one slave and a write grant at another slave in the same cycle, and write priority is decided on write requests alone.
- R9: A forwarded write carries the winning master's address, data and byte enable unchanged.
- R10: While rst_n is low, no slave request and no master grant is asserted. Driving rst_n low clears any pending read return at once, so read data goes to zero.
- R11: Slave 4 decodes exactly 0x0003_0000 to 0x0003_0003. Address 0x0003_0003 hits slave 4, and 0x0003_0004 hits no slave.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous clear of read-return state |
| m_rd_req | input | NM | Read request per master |
| m_rd_be | input | NM x BW | Read byte enable per master |
| m_rd_addr | input | NM x AW | Read address per master |
| m_rd_data | output | NM x DW | Read data returned per master |
| m_rd_gnt | output | NM | Read grant per master |
| m_wr_req | input | NM | Write request per master |
| m_wr_be | input | NM x BW | Write byte enable per master |
| m_wr_addr | input | NM x AW | Write address per master |
| m_wr_data | input | NM x DW | Write data per master |
| m_wr_gnt | output | NM | Write grant per master |
| s_rd_req | output | NS | Read request per slave |
| s_rd_be | output | NS x BW | Read byte enable per slave |
| s_rd_addr | output | NS x AW | Read address per slave |
| s_rd_data | input | NS x DW | Read data from each slave, valid the cycle after its grant |
| s_rd_gnt | input | NS | Read grant from each slave |
| s_wr_req | output | NS | Write request per slave |
| s_wr_be | output | NS x BW | Write byte enable per slave |
| s_wr_addr | output | NS x AW | Write address per slave |
| s_wr_data | output | NS x DW | Write data per slave |
| s_wr_gnt | input | NS | Write grant from each slave |

## Verification
Forwarded requests, addresses and grants are combinational, so they are due in the same cycle as the stimulus. The bench applies each vector on the falling edge and samples those outputs one nanosecond later, before the next rising edge. Read data is due one rising edge after the grant. The check for vector k therefore compares the read data against the grants and slave indices expected for vector k-1. The reset clear is asynchronous and is sampled shortly after rst_n falls, with no edge in between.

// File: rtl/bus_prio_router.sv
module bus_prio_router #(
  parameter int NM = 3,
  parameter int NS = 6,
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int BW = 4,
  parameter logic [NS-1:0][AW-1:0] SLV_BASE = {32'h0003_1000, 32'h0003_0000, 32'h0002_0000,
                                               32'h0001_0000, 32'h0000_8000, 32'h0000_0000},
  parameter logic [NS-1:0][AW-1:0] SLV_MASK = {32'h0000_000F, 32'h0000_0003, 32'h0000_0FFF,
                                               32'h0000_0FFF, 32'h0000_0FFF, 32'h0000_0FFF}
)(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NM-1:0]          m_rd_req,
  input  logic [NM-1:0][BW-1:0]  m_rd_be,
  input  logic [NM-1:0][AW-1:0]  m_rd_addr,
  output logic [NM-1:0][DW-1:0]  m_rd_data,
  output logic [NM-1:0]          m_rd_gnt,
  input  logic [NM-1:0]          m_wr_req,
  input  logic [NM-1:0][BW-1:0]  m_wr_be,
  input  logic [NM-1:0][AW-1:0]  m_wr_addr,
  input  logic [NM-1:0][DW-1:0]  m_wr_data,
  output logic [NM-1:0]          m_wr_gnt,
  output logic [NS-1:0]          s_rd_req,
  output logic [NS-1:0][BW-1:0]  s_rd_be,
  output logic [NS-1:0][AW-1:0]  s_rd_addr,
  input  logic [NS-1:0][DW-1:0]  s_rd_data,
  input  logic [NS-1:0]          s_rd_gnt,
  output logic [NS-1:0]          s_wr_req,
  output logic [NS-1:0][BW-1:0]  s_wr_be,
  output logic [NS-1:0][AW-1:0]  s_wr_addr,
  output logic [NS-1:0][DW-1:0]  s_wr_data,
  input  logic [NS-1:0]          s_wr_gnt
);
  localparam int SIW = (NS > 1) ? $clog2(NS) : 1;
  localparam int MIW = (NM > 1) ? $clog2(NM) : 1;

  logic [NM-1:0]          rd_hit, wr_hit;
  logic [NM-1:0][SIW-1:0] rd_sidx, wr_sidx;
  logic [NS-1:0]          rd_busy, wr_busy;
  logic [NS-1:0][MIW-1:0] rd_own, wr_own;

  logic [NM-1:0]          pend_v, pend_miss;
  logic [NM-1:0][SIW-1:0] pend_sidx;

  // address decode, lowest slave index wins on overlap (R1, R11)
  always_comb begin
    rd_hit  = '0;
    wr_hit  = '0;
    rd_sidx = '0;
    wr_sidx = '0;
    for (int m = 0; m < NM; m++) begin
      for (int s = NS - 1; s >= 0; s--) begin
        if ((m_rd_addr[m] & ~SLV_MASK[s]) == SLV_BASE[s]) begin
          rd_hit[m]  = 1'b1;
          rd_sidx[m] = SIW'(s);
        end
        if ((m_wr_addr[m] & ~SLV_MASK[s]) == SLV_BASE[s]) begin
          wr_hit[m]  = 1'b1;
          wr_sidx[m] = SIW'(s);
        end
      end
    end
  end

  // per-slave fixed-priority pick, lowest master index wins (R2, R3, R8)
  always_comb begin
    rd_busy = '0;
    wr_busy = '0;
    rd_own  = '0;
    wr_own  = '0;
    for (int s = 0; s < NS; s++) begin
      for (int m = NM - 1; m >= 0; m--) begin
        if (m_rd_req[m] && rd_hit[m] && rd_sidx[m] == SIW'(s)) begin
          rd_busy[s] = 1'b1;
          rd_own[s]  = MIW'(m);
        end
        if (m_wr_req[m] && wr_hit[m] && wr_sidx[m] == SIW'(s)) begin
          wr_busy[s] = 1'b1;
          wr_own[s]  = MIW'(m);
        end
      end
    end
  end

  generate
    for (genvar s = 0; s < NS; s++) begin : g_slv
      assign s_rd_req[s]  = rst_n & rd_busy[s];
      assign s_rd_addr[s] = m_rd_addr[rd_own[s]];
      assign s_rd_be[s]   = m_rd_be[rd_own[s]];
      assign s_wr_req[s]  = rst_n & wr_busy[s];
      assign s_wr_addr[s] = m_wr_addr[wr_own[s]];
      assign s_wr_data[s] = m_wr_data[wr_own[s]];
      assign s_wr_be[s]   = m_wr_be[wr_own[s]];
    end

    for (genvar m = 0; m < NM; m++) begin : g_mst
      // misses are granted at once (R5, R6); hits follow the slave grant (R4)
      assign m_rd_gnt[m] = rst_n & m_rd_req[m] &
                           (~rd_hit[m] | (rd_own[rd_sidx[m]] == MIW'(m) & s_rd_gnt[rd_sidx[m]]));
      assign m_wr_gnt[m] = rst_n & m_wr_req[m] &
                           (~wr_hit[m] | (wr_own[wr_sidx[m]] == MIW'(m) & s_wr_gnt[wr_sidx[m]]));
      assign m_rd_data[m] = (pend_v[m] & ~pend_miss[m]) ? s_rd_data[pend_sidx[m]] : '0;
    end
  endgenerate

  // one-cycle read-return steering (R7, R10)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_v    <= '0;
      pend_miss <= '0;
      pend_sidx <= '0;
    end else begin
      pend_v    <= m_rd_gnt;
      pend_miss <= ~rd_hit;
      pend_sidx <= rd_sidx;
    end
  end
endmodule

module bus_prio_router_chk #(
  parameter int NM = 3,
  parameter int NS = 6,
  parameter int AW = 32,
  parameter int DW = 32
)(
  input logic                  clk,
  input logic                  rst_n,
  input logic [NM-1:0]         m_rd_req,
  input logic [NM-1:0][AW-1:0] m_rd_addr,
  input logic [NM-1:0][DW-1:0] m_rd_data,
  input logic [NM-1:0]         m_rd_gnt,
  input logic [NM-1:0]         m_wr_req,
  input logic [NM-1:0]         m_wr_gnt,
  input logic [NS-1:0]         s_rd_req,
  input logic [NS-1:0]         s_rd_gnt,
  input logic [NS-1:0]         s_wr_req,
  input logic [NS-1:0]         s_wr_gnt
);
  AST_QUIET_IN_RESET: assert property (@(posedge clk)
    !rst_n |-> (s_rd_req == '0 && s_wr_req == '0 && m_rd_gnt == '0 && m_wr_gnt == '0)); // R10

  AST_GNT_HAS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    ((m_rd_gnt & ~m_rd_req) == '0) && ((m_wr_gnt & ~m_wr_req) == '0)); // R4

  AST_FWD_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(s_rd_req) <= $countones(m_rd_req) &&
    $countones(s_wr_req) <= $countones(m_wr_req)); // R1

  generate
    if (NM > 1) begin : g_prio
      AST_SAME_ADDR_PRIO: assert property (@(posedge clk) disable iff (!rst_n)
        (m_rd_gnt[1] && m_rd_req[0] && m_rd_addr[0] == m_rd_addr[1]) |-> m_rd_gnt[0]); // R2
    end
    for (genvar m = 0; m < NM; m++) begin : g_m
      AST_RDATA_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        $past(m_rd_gnt[m]) || m_rd_data[m] == '0); // R7
    end
    for (genvar s = 0; s < NS; s++) begin : g_s
      AST_SLV_GNT_REACHES: assert property (@(posedge clk) disable iff (!rst_n)
        ((s_rd_req[s] && s_rd_gnt[s]) |-> m_rd_gnt != '0) and
        ((s_wr_req[s] && s_wr_gnt[s]) |-> m_wr_gnt != '0)); // R4
    end
  endgenerate
endmodule

bind bus_prio_router bus_prio_router_chk #(.NM(NM), .NS(NS), .AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .m_rd_req(m_rd_req), .m_rd_addr(m_rd_addr), .m_rd_data(m_rd_data), .m_rd_gnt(m_rd_gnt),
  .m_wr_req(m_wr_req), .m_wr_gnt(m_wr_gnt),
  .s_rd_req(s_rd_req), .s_rd_gnt(s_rd_gnt), .s_wr_req(s_wr_req), .s_wr_gnt(s_wr_gnt)
);

// File: tb/bus_prio_router_tb.sv
`timescale 1ns/1ps
module bus_prio_router_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [2:0]        m_rd_req = '0, m_rd_gnt, m_wr_req = '0, m_wr_gnt;
  logic [2:0][3:0]   m_rd_be = '0, m_wr_be = '0;
  logic [2:0][31:0]  m_rd_addr = '0, m_rd_data, m_wr_addr = '0, m_wr_data = '0;
  logic [5:0]        s_rd_req, s_wr_req, s_rd_gnt = '1, s_wr_gnt = '1;
  logic [5:0][3:0]   s_rd_be, s_wr_be;
  logic [5:0][31:0]  s_rd_addr, s_rd_data, s_wr_addr, s_wr_data;

  for (genvar s = 0; s < 6; s++) begin : g_sd
    assign s_rd_data[s] = 32'hD000_0000 | s;
  end

  bus_prio_router u_dut (
    .clk(clk), .rst_n(rst_n),
    .m_rd_req(m_rd_req), .m_rd_be(m_rd_be), .m_rd_addr(m_rd_addr), .m_rd_data(m_rd_data), .m_rd_gnt(m_rd_gnt),
    .m_wr_req(m_wr_req), .m_wr_be(m_wr_be), .m_wr_addr(m_wr_addr), .m_wr_data(m_wr_data), .m_wr_gnt(m_wr_gnt),
    .s_rd_req(s_rd_req), .s_rd_be(s_rd_be), .s_rd_addr(s_rd_addr), .s_rd_data(s_rd_data), .s_rd_gnt(s_rd_gnt),
    .s_wr_req(s_wr_req), .s_wr_be(s_wr_be), .s_wr_addr(s_wr_addr), .s_wr_data(s_wr_data), .s_wr_gnt(s_wr_gnt)
  );

  localparam logic [31:0] A0 = 32'h0000_0010, A1 = 32'h0000_8020, A2 = 32'h0001_0ABC,
                          A3 = 32'h0002_0004, A4 = 32'h0003_0003, A4X = 32'h0003_0004,
                          A5 = 32'h0003_100C, MS = 32'h0004_0000, Z = 32'h0;

  typedef struct packed {
    logic [2:0]       rreq;
    logic [2:0][31:0] raddr;
    logic [2:0]       wreq;
    logic [2:0][31:0] waddr;
    logic [5:0]       sgr, sgw;
    logic [5:0]       e_srreq, e_swreq;
    logic [2:0]       e_mrgnt, e_mwgnt;
    logic [2:0][2:0]  rsrc;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VEC [NV] = '{
    '{3'b111, {A1,A0,A0}, 3'b000, {Z,Z,Z},     6'h3F, 6'h3F, 6'h03, 6'h00, 3'b101, 3'b000, {3'd1,3'd7,3'd0}}, // R2 R3
    '{3'b110, {A2,A2,A0}, 3'b000, {Z,Z,Z},     6'h3F, 6'h3F, 6'h04, 6'h00, 3'b010, 3'b000, {3'd7,3'd2,3'd7}}, // R2 R7
    '{3'b111, {MS,MS,MS}, 3'b000, {Z,Z,Z},     6'h3F, 6'h3F, 6'h00, 6'h00, 3'b111, 3'b000, {3'd7,3'd7,3'd7}}, // R5
    '{3'b111, {A5,A4X,A4},3'b000, {Z,Z,Z},     6'h3F, 6'h3F, 6'h30, 6'h00, 3'b111, 3'b000, {3'd5,3'd7,3'd4}}, // R11 R3
    '{3'b000, {Z,Z,Z},    3'b111, {MS,A3,A3},  6'h3F, 6'h3F, 6'h00, 6'h08, 3'b000, 3'b101, {3'd7,3'd7,3'd7}}, // R6 R2 R7 R11
    '{3'b100, {A3,Z,Z},   3'b010, {Z,A1,Z},    6'h37, 6'h3D, 6'h08, 6'h02, 3'b000, 3'b000, {3'd7,3'd7,3'd7}}, // R4
    '{3'b010, {Z,A5,Z},   3'b011, {Z,A2,A2},   6'h3F, 6'h3F, 6'h20, 6'h04, 3'b010, 3'b001, {3'd7,3'd5,3'd7}}, // R8
    '{3'b000, {Z,Z,Z},    3'b000, {Z,Z,Z},     6'h3F, 6'h3F, 6'h00, 6'h00, 3'b000, 3'b000, {3'd7,3'd7,3'd7}}  // R7
  };

  int n_chk = 0, n_fail = 0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_data(input int k, input int m);
    if (k == 0 || !VEC[k-1].e_mrgnt[m] || VEC[k-1].rsrc[m] == 3'd7) return 32'h0;
    return 32'hD000_0000 | 32'(VEC[k-1].rsrc[m]);
  endfunction

  task automatic idle();
    m_rd_req = '0; m_wr_req = '0; s_rd_gnt = '1; s_wr_gnt = '1;
  endtask

  initial begin
    #80000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    // reset state: requests present but nothing forwarded or granted
    @(negedge clk);
    m_rd_req = 3'b011; m_rd_addr = {Z, MS, A0};
    m_wr_req = 3'b001; m_wr_addr = {Z, Z, A1};
    #1;
    chk("R10 slave rd req in reset", 64'(s_rd_req), 64'h0);
    chk("R10 slave wr req in reset", 64'(s_wr_req), 64'h0);
    chk("R10 master gnt in reset", 64'({m_rd_gnt, m_wr_gnt}), 64'h0);
    @(negedge clk);
    idle();
    rst_n = 1'b1;
    #1;
    chk("R10 rdata zero after reset", 64'(m_rd_data[0]), 64'h0);

    // vector table
    for (int k = 0; k < NV; k++) begin
      @(negedge clk);
      m_rd_req = VEC[k].rreq; m_rd_addr = VEC[k].raddr; m_rd_be = '1;
      m_wr_req = VEC[k].wreq; m_wr_addr = VEC[k].waddr; m_wr_be = '1;
      s_rd_gnt = VEC[k].sgr;  s_wr_gnt = VEC[k].sgw;
      #1;
      chk($sformatf("vec%0d slave rd req", k), 64'(s_rd_req), 64'(VEC[k].e_srreq));
      chk($sformatf("vec%0d slave wr req", k), 64'(s_wr_req), 64'(VEC[k].e_swreq));
      chk($sformatf("vec%0d master rd gnt", k), 64'(m_rd_gnt), 64'(VEC[k].e_mrgnt));
      chk($sformatf("vec%0d master wr gnt", k), 64'(m_wr_gnt), 64'(VEC[k].e_mwgnt));
      for (int m = 0; m < 3; m++)
        chk($sformatf("R7 vec%0d rdata m%0d", k, m), 64'(m_rd_data[m]), 64'(exp_data(k, m)));
    end

    // R1: read address and byte enable forwarded unchanged
    @(negedge clk);
    idle();
    m_rd_req = 3'b010; m_rd_addr = {Z, A2, Z}; m_rd_be = {4'h0, 4'h6, 4'h0};
    #1;
    chk("R1 rd addr to slave 2", 64'(s_rd_addr[2]), 64'(A2));
    chk("R1 rd be to slave 2", 64'(s_rd_be[2]), 64'h6);

    // R9: write fields forwarded unchanged
    @(negedge clk);
    idle();
    m_wr_req = 3'b100; m_wr_addr = {A5, Z, Z};
    m_wr_data = {32'h1234_5678, 32'h0, 32'h0}; m_wr_be = {4'hC, 4'h0, 4'h0};
    #1;
    chk("R9 wr req slave 5", 64'(s_wr_req), 64'h20);
    chk("R9 wr addr slave 5", 64'(s_wr_addr[5]), 64'(A5));
    chk("R9 wr data slave 5", 64'(s_wr_data[5]), 64'h1234_5678);
    chk("R9 wr be slave 5", 64'(s_wr_be[5]), 64'hC);

    // R10: reset drops a pending read return at once
    @(negedge clk);
    idle();
    m_rd_req = 3'b001; m_rd_addr = {Z, Z, A0};
    @(posedge clk);
    #0.5;
    rst_n = 1'b0;
    #0.5;
    chk("R10 pending read cleared", 64'(m_rd_data[0]), 64'h0);
    @(negedge clk);
    idle();
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    chk("R10 rdata idle after release", 64'(m_rd_data[0]), 64'h0);

    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule